// File: doc/BRIEF.md
# Serial DAC Write Controller

This controller runs on a system clock and writes 12-bit codes into an external serial multiplying converter over three wires: a serial clock, a data line and an active-low load strobe. A fourth wire, an active-low clear, is also driven. The host hands over a code with a valid/ready handshake. The controller then shifts the code out with the most significant bit first. The serial clock rests low, and data moves only when the controller drives that clock low. After the last bit it drops the load strobe for a minimum width, waits a recovery gap, and becomes ready again.

A single-cycle clear request produces a clear pulse of minimum width. If the request arrives while a frame is in flight, it is held until that frame has finished, including its load and recovery. Every timing minimum is a parameter in nanoseconds, together with the system clock period. Each minimum is turned into a whole number of clock cycles, rounded up. A clock phase also has to cover the data setup or hold time that falls inside it.

Top module: `dac_wr_ctrl`

## Requirements
- R1: During and immediately after reset, `dac_sclk` is 0, `dac_load_n` is 1, `dac_clr_n` is 1 and `code_ready` is 1. A reset in the middle of a frame abandons that frame without a load pulse.
- R2: A code is taken on a clock edge where `code_valid` and `code_ready` are both 1. `code_ready` is 0 from the next cycle until the controller is idle again with no clear pending.
- R3: Each frame gives exactly 12 rising edges of `dac_sclk`. The value of `dac_sdin` at the k-th rising edge is bit 11-k+1 of the taken code, so the MSB goes first. The 12 sampled bits equal the code.
- R4: Every high phase of `dac_sclk` lasts at least HI_CYC = max(ceil(SCLK_HI_NS/CLK_NS), ceil(HOLD_NS/CLK_NS)) cycles. Every low phase lasts at least LO_CYC = max(ceil(SCLK_LO_NS/CLK_NS), ceil(SETUP_NS/CLK_NS)) cycles. This gives at least 25 ns for each phase at the defaults.
- R5: `dac_sdin` changes only while `dac_sclk` is low. It is stable at least SETUP_NS before each rising edge and at least HOLD_NS after it.
- R6: `dac_load_n` falls no earlier than the 12th rising edge, with `dac_sclk` low. It stays low for ceil(LOAD_NS/CLK_NS) cycles, at least 20 ns, and `dac_sclk` stays low throughout.
- R7: At least ceil(RECOV_NS/CLK_NS) cycles pass between `dac_load_n` rising and `code_ready` returning. No rising `dac_sclk` edge comes within RECOV_NS of `dac_load_n` rising.
- R8: A `clr_req` pulse seen while idle drives `dac_clr_n` low for ceil(CLR_NS/CLK_NS) cycles, at least 20 ns, with `code_ready` at 0.
- R9: A `clr_req` that arrives during a frame does not touch `dac_clr_n` until the frame's load pulse and recovery have finished. The frame's code is delivered intact.
- R10: A pending clear takes priority over new codes. `code_ready` is 0 from the cycle after `clr_req`, and the next frame starts only after the clear pulse has ended.
- R11: `dac_load_n` and `dac_clr_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | Host offers a code |
| code_data | input | 12 | Code to write |
| code_ready | output | 1 | Controller idle and accepting a code |
| clr_req | input | 1 | Request for a clear pulse |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdin | output | 1 | Serial data, MSB first |
| dac_load_n | output | 1 | Active-low load strobe |
| dac_clr_n | output | 1 | Active-low clear strobe |

## Verification
The assertions assume three things about the inputs. First, `clk` really has the period given by CLK_NS. Second, `code_data` holds steady while `code_valid` waits for `code_ready`. Third, every timer is started with a nonzero length. The stimulus changes the inputs only on falling clock edges and holds `code_valid` until the code is taken. It sends `clr_req` as one-cycle pulses, so two requests never merge unintentionally. A receiver model in the bench timestamps every wire edge and checks each minimum in nanoseconds. It also latches the shifted bits when the load strobe rises and compares them with the code that was sent.

// File: rtl/dacw_pkg.sv
`timescale 1ns/1ps
package dacw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SHIFT   = 3'd1,
    ST_LOAD    = 3'd2,
    ST_RECOVER = 3'd3,
    ST_CLEAR   = 3'd4
  } dacw_state_e;

  // Whole clock cycles covering a minimum time, never below one.
  function automatic int dacw_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int dacw_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacw_timer.sv
`timescale 1ns/1ps
module dacw_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  // A load of N makes done rise after N-1 further edges, so the state lasts N cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R4
  tmr_len_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (len != '0));

  // R4
  tmr_run_chk: assert property (@(posedge clk) disable iff (rst)
    (load && len > 1) |=> !done);

endmodule

// File: rtl/dacw_shifter.sv
`timescale 1ns/1ps
module dacw_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         sout,
  output logic         last
);

  localparam int BC_W = $clog2(W + 1);

  logic [W-1:0]    sr_q;
  logic [BC_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sr_q   <= din;
      left_q <= BC_W'(W);
    end else if (shift) begin
      sr_q   <= {sr_q[W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign sout = sr_q[W-1];
  assign last = (left_q == BC_W'(1));

  // R3
  shift_bound_chk: assert property (@(posedge clk) disable iff (rst)
    shift |-> (left_q > BC_W'(1)));

  // R3
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));

endmodule

// File: rtl/dac_wr_ctrl.sv
`timescale 1ns/1ps
module dac_wr_ctrl
  import dacw_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int CLK_NS     = 8,
  parameter int SCLK_HI_NS = 25,
  parameter int SCLK_LO_NS = 25,
  parameter int SETUP_NS   = 15,
  parameter int HOLD_NS    = 15,
  parameter int LOAD_NS    = 20,
  parameter int RECOV_NS   = 15,
  parameter int CLR_NS     = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_valid,
  input  logic [DATA_W-1:0] code_data,
  output logic              code_ready,
  input  logic              clr_req,
  output logic              dac_sclk,
  output logic              dac_sdin,
  output logic              dac_load_n,
  output logic              dac_clr_n
);

  localparam int HI_CYC  = dacw_max(dacw_cycles(SCLK_HI_NS, CLK_NS), dacw_cycles(HOLD_NS, CLK_NS));
  localparam int LO_CYC  = dacw_max(dacw_cycles(SCLK_LO_NS, CLK_NS), dacw_cycles(SETUP_NS, CLK_NS));
  localparam int LD_CYC  = dacw_cycles(LOAD_NS, CLK_NS);
  localparam int REC_CYC = dacw_cycles(RECOV_NS, CLK_NS);
  localparam int CLR_CYC = dacw_cycles(CLR_NS, CLK_NS);
  localparam int MAX_CYC = dacw_max(dacw_max(dacw_max(HI_CYC, LO_CYC), dacw_max(LD_CYC, REC_CYC)), CLR_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  dacw_state_e      state_q, state_d;
  logic             phase_hi_q, phase_hi_d;
  logic             pend_q, pend_d;
  logic             sclk_q, sclk_d;
  logic             load_n_q, load_n_d;
  logic             clr_n_q, clr_n_d;
  logic             ready_q, ready_d;
  logic             take_clr;

  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_len;
  logic             sh_load, sh_shift, sh_sout, sh_last;

  dacw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .len  (tmr_len),
    .done (tmr_done)
  );

  dacw_shifter #(.W(DATA_W)) u_shifter (
    .clk   (clk),
    .rst   (rst),
    .load  (sh_load),
    .shift (sh_shift),
    .din   (code_data),
    .sout  (sh_sout),
    .last  (sh_last)
  );

  always_comb begin
    state_d    = state_q;
    phase_hi_d = phase_hi_q;
    sclk_d     = sclk_q;
    load_n_d   = load_n_q;
    clr_n_d    = clr_n_q;
    tmr_load   = 1'b0;
    tmr_len    = '0;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    take_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_q) begin
          state_d  = ST_CLEAR;
          clr_n_d  = 1'b0;
          take_clr = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(CLR_CYC);
        end else if (code_valid && ready_q) begin
          state_d    = ST_SHIFT;
          phase_hi_d = 1'b0;
          sh_load    = 1'b1;
          tmr_load   = 1'b1;
          tmr_len    = CNT_W'(LO_CYC);
        end
      end
      ST_SHIFT: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (!phase_hi_q) begin
            sclk_d     = 1'b1;
            phase_hi_d = 1'b1;
            tmr_len    = CNT_W'(HI_CYC);
          end else begin
            sclk_d     = 1'b0;
            phase_hi_d = 1'b0;
            if (sh_last) begin
              state_d  = ST_LOAD;
              load_n_d = 1'b0;
              tmr_len  = CNT_W'(LD_CYC);
            end else begin
              sh_shift = 1'b1;
              tmr_len  = CNT_W'(LO_CYC);
            end
          end
        end
      end
      ST_LOAD: begin
        if (tmr_done) begin
          state_d  = ST_RECOVER;
          load_n_d = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(REC_CYC);
        end
      end
      ST_RECOVER: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      ST_CLEAR: begin
        if (tmr_done) begin
          state_d = ST_IDLE;
          clr_n_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    pend_d  = (pend_q || clr_req) && !take_clr;
    ready_d = (state_d == ST_IDLE) && !pend_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      phase_hi_q <= 1'b0;
      pend_q     <= 1'b0;
      sclk_q     <= 1'b0;
      load_n_q   <= 1'b1;
      clr_n_q    <= 1'b1;
      ready_q    <= 1'b1;
    end else begin
      state_q    <= state_d;
      phase_hi_q <= phase_hi_d;
      pend_q     <= pend_d;
      sclk_q     <= sclk_d;
      load_n_q   <= load_n_d;
      clr_n_q    <= clr_n_d;
      ready_q    <= ready_d;
    end
  end

  assign code_ready = ready_q;
  assign dac_sclk   = sclk_q;
  assign dac_sdin   = sh_sout;
  assign dac_load_n = load_n_q;
  assign dac_clr_n  = clr_n_q;

  // Phase-length monitor for the assertions: cycles the previous sclk level was held.
  logic             sclk_dly_q;
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_dly_q <= 1'b0;
      run_q      <= '0;
    end else begin
      sclk_dly_q <= sclk_q;
      if (sclk_q != sclk_dly_q) run_q <= CNT_W'(1);
      else if (run_q != {CNT_W{1'b1}}) run_q <= run_q + 1'b1;
    end
  end

  // R4
  sclk_low_len_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && !sclk_dly_q) |-> (run_q >= CNT_W'(LO_CYC)));

  // R4
  sclk_high_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!sclk_q && sclk_dly_q) |-> (run_q >= CNT_W'(HI_CYC)));

  // R5
  sdin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdin));

  // R6
  load_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    !dac_load_n |-> !dac_sclk);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    code_ready |-> (!dac_sclk && dac_load_n && dac_clr_n));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!dac_load_n && !dac_clr_n));

  // R9
  clr_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_clr_n) |-> ($past(dac_load_n) && !$past(dac_sclk)));

endmodule

// File: tb/dac_wr_ctrl_tb.sv
`timescale 1ns/1ps
module dac_wr_ctrl_tb;

  localparam int TCLK    = 8;
  localparam int HI_MIN  = 25;
  localparam int LO_MIN  = 25;
  localparam int SU_MIN  = 15;
  localparam int HD_MIN  = 15;
  localparam int LD_MIN  = 20;
  localparam int REC_MIN = 15;
  localparam int CLR_MIN = 20;
  localparam int NVEC    = 8;
  // {code sent, code expected in receiver}
  localparam logic [23:0] VEC [NVEC] = '{
    {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h800, 12'h800}, {12'h001, 12'h001},
    {12'hA5A, 12'hA5A}, {12'h5A5, 12'h5A5}, {12'h7FF, 12'h7FF}, {12'h123, 12'h123}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        code_valid = 1'b0;
  logic [11:0] code_data = '0;
  logic        clr_req = 1'b0;
  logic        code_ready, dac_sclk, dac_sdin, dac_load_n, dac_clr_n;

  always #(TCLK/2) clk = ~clk;

  dac_wr_ctrl u_dut (
    .clk(clk), .rst(rst), .code_valid(code_valid), .code_data(code_data),
    .code_ready(code_ready), .clr_req(clr_req), .dac_sclk(dac_sclk),
    .dac_sdin(dac_sdin), .dac_load_n(dac_load_n), .dac_clr_n(dac_clr_n)
  );

  int nchk = 0, nfail = 0;   // main-flow checks
  int mchk = 0, mfail = 0;   // receiver-model checks

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Receiver model: timestamps every wire edge and checks minimums.
  realtime t_rise = -1.0e6, t_fall = -1.0e6, t_dchg = -1.0e6;
  realtime t_ldf = -1.0e6, t_ldr = -1.0e6, t_clrf = -1.0e6, t_clrr = -1.0e6;
  realtime t_rst = 0.0, t_fstart = -1.0e6;
  logic [11:0] rx = '0, latched = '0;
  int nbits = 0, nlat = 0, nclr = 0;
  logic p_sclk = 1'b0, p_ld = 1'b1, p_clr = 1'b1, p_sd = 1'b0;

  task automatic mon(input bit ok, input string req, input realtime act, input int lim);
    mchk++;
    if (!ok) begin
      mfail++;
      $display("FAIL %s: actual %0d ns expected >= %0d ns", req, int'(act), lim);
    end
  endtask

  always @(dac_sclk or dac_load_n or dac_clr_n or dac_sdin or rst) begin
    realtime now;
    now = $realtime;
    if (rst) begin
      t_rst = now;
    end else begin
      if (dac_sdin !== p_sd) begin
        mon(now - t_rise >= HD_MIN, "R5 hold", now - t_rise, HD_MIN);
        mon(dac_sclk == 1'b0, "R5 sdin moved with sclk high", 1, 0);
        t_dchg = now;
      end
      if (dac_sclk && !p_sclk) begin
        mon(now - t_fall >= LO_MIN, "R4 low phase", now - t_fall, LO_MIN);
        mon(now - t_dchg >= SU_MIN, "R5 setup", now - t_dchg, SU_MIN);
        mon(now - t_ldr >= REC_MIN, "R7 load-to-sclk gap", now - t_ldr, REC_MIN);
        if (t_ldr > t_rise || t_rst > t_rise) begin
          nbits = 1; rx = {11'b0, dac_sdin}; t_fstart = now;
        end else begin
          nbits++; rx = {rx[10:0], dac_sdin};
        end
        t_rise = now;
      end
      if (!dac_sclk && p_sclk) begin
        mon(now - t_rise >= HI_MIN, "R4 high phase", now - t_rise, HI_MIN);
        t_fall = now;
      end
      if (!dac_load_n && p_ld) begin
        mon(nbits == 12, "R3 bits before load", nbits, 12);
        mon(now - t_rise >= 0.0, "R6 load after last edge", now - t_rise, 0);
        t_ldf = now;
      end
      if (dac_load_n && !p_ld) begin
        mon(now - t_ldf >= LD_MIN, "R6 load width", now - t_ldf, LD_MIN);
        latched = rx; nlat++; t_ldr = now;
      end
      if (!dac_clr_n && p_clr) t_clrf = now;
      if (dac_clr_n && !p_clr) begin
        mon(now - t_clrf >= CLR_MIN, "R8 clear width", now - t_clrf, CLR_MIN);
        nclr++; t_clrr = now;
      end
    end
    p_sclk = dac_sclk; p_ld = dac_load_n; p_clr = dac_clr_n; p_sd = dac_sdin;
  end

  task automatic send(input logic [11:0] c);
    @(negedge clk);
    while (!code_ready) @(negedge clk);
    code_valid = 1'b1; code_data = c;
    @(negedge clk);
    code_valid = 1'b0;
    chk(code_ready == 1'b0, "R2 ready drops after accept", code_ready, 0);
  endtask

  task automatic wait_latch(input int prev);
    int k;
    k = 0;
    while (nlat == prev && k < 3000) begin @(negedge clk); k++; end
    chk(nlat == prev + 1, "R3 frame latched", nlat, prev + 1);
  endtask

  task automatic wait_clear(input int prev);
    int k;
    k = 0;
    while (nclr == prev && k < 3000) begin @(negedge clk); k++; end
    chk(nclr == prev + 1, "R8 clear pulse seen", nclr, prev + 1);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk + mchk, nfail + mfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n0, c0, k;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(dac_sclk == 0 && dac_load_n == 1 && dac_clr_n == 1, "R1 outputs in reset",
        {dac_sclk, dac_load_n, dac_clr_n}, 3'b011);
    chk(code_ready == 1, "R1 ready in reset", code_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(code_ready == 1 && dac_sclk == 0, "R1 idle after reset", {code_ready, dac_sclk}, 2'b10);

    // Vector table: R2, R3, R4, R5, R6, R7
    for (int i = 0; i < NVEC; i++) begin
      n0 = nlat;
      send(VEC[i][23:12]);
      wait_latch(n0);
      chk(latched == VEC[i][11:0], "R3 latched code", latched, VEC[i][11:0]);
      k = 0;
      while (!code_ready && k < 100) begin @(negedge clk); k++; end
      chk(($realtime - t_ldr) >= REC_MIN, "R7 recovery before ready", int'($realtime - t_ldr), REC_MIN);
    end

    // R8: clear while idle
    c0 = nclr;
    pulse_clr();
    chk(code_ready == 0, "R8 ready low for clear", code_ready, 0);
    wait_clear(c0);

    // R9: clear during a frame is deferred
    n0 = nlat; c0 = nclr;
    send(12'h3C3);
    repeat (20) @(negedge clk);
    pulse_clr();
    k = 0;
    while (nlat == n0 && k < 3000) begin
      chk(dac_clr_n == 1, "R9 clear held during frame", dac_clr_n, 1);
      @(negedge clk); k++;
    end
    chk(latched == 12'h3C3, "R9 frame intact", latched, 12'h3C3);
    wait_clear(c0);
    chk(t_clrf - t_ldr >= REC_MIN, "R9 clear after recovery", int'(t_clrf - t_ldr), REC_MIN);

    // R10: pending clear beats a waiting code
    n0 = nlat; c0 = nclr;
    pulse_clr();
    chk(code_ready == 0, "R10 ready low while clear pending", code_ready, 0);
    send(12'h6E1);
    wait_latch(n0);
    chk(nclr == c0 + 1, "R10 clear before frame", nclr, c0 + 1);
    chk(t_fstart > t_clrr, "R10 frame after clear", int'(t_fstart), int'(t_clrr));
    chk(latched == 12'h6E1, "R10 code after clear", latched, 12'h6E1);

    // R1: reset in the middle of a frame
    n0 = nlat;
    send(12'h9B4);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dac_sclk == 0 && dac_load_n == 1 && code_ready == 1, "R1 mid-frame reset",
        {dac_sclk, dac_load_n, code_ready}, 3'b011);
    chk(nlat == n0, "R1 no load after reset", nlat, n0);
    send(12'hFFE);
    wait_latch(n0);
    chk(latched == 12'hFFE, "R3 frame after reset", latched, 12'hFFE);

    // R11: strobes exclusive across a back-to-back clear and frame
    c0 = nclr; n0 = nlat;
    pulse_clr();
    wait_clear(c0);
    send(12'h0F0);
    wait_latch(n0);
    chk(latched == 12'h0F0, "R11 frame after clear", latched, 12'h0F0);

    repeat (10) @(negedge clk);
    summary();
    $finish;
  end

endmodule